// File: doc/BRIEF.md
# Eight-Operand Carry-Save Summing Tree

This block adds eight unsigned operands of equal width in one combinational pass and returns their exact total. It does not chain two-input adders. The operands enter a tree of carry-save compressor layers. Each compressor takes three vectors and turns them into two: a sum vector and a carry vector. The compressor is a row of full adders that share no carry signal between bit positions, so each layer costs one full-adder delay whatever the operand width.

The layers cut the vector count from 8 to 6, then to 4, 3 and 2. At each layer the vectors are grouped in threes. A vector left over, which cannot complete a group, passes unchanged to the next layer. Only the last two vectors go through a carry-propagating adder, which is a parallel-prefix design with logarithmic depth. All internal vectors are zero-extended to the output width of operand width plus three bits. This width holds eight maximum-valued operands, so no carry is ever dropped.

A datapath places the block where many terms must be added in one step. The data inputs and the result are plain combinational signals with no handshake, because the block holds no state.

Top module: `csa_reduce8`

## Requirements
- R1: `total_o` equals the exact arithmetic sum of the eight operand fields for every input combination. Operand k occupies bits `[k*OP_W +: OP_W]` of `opnd_i`, and all operands are unsigned.
- R2: `total_o` is `OP_W+3` bits wide. With every operand all ones, it equals `8*(2^OP_W-1)` without wrapping.
- R3: Every compressor layer preserves the arithmetic total of its vectors. The layers hold 6, 4, 3 and 2 vectors in turn, and the sum of the final two vectors is below `2^(OP_W+3)`.
- R4: Each carry vector is its full-adder carries moved up one bit position, so bit 0 of every carry vector is 0. For example, three operands equal to 1 give a total of 3.
- R5: Result bit j depends only on operand bits 0..j. Changing the operand bits above position j leaves `total_o[j:0]` unchanged.
- R6: All-zero operands give a total of 0.
- R7: A single nonzero operand, in any of the eight slots, appears unchanged at the output. This includes the slots that skip a compressor in a layer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 8*OP_W | Eight unsigned operands packed side by side, operand k at bits `[k*OP_W +: OP_W]` |
| total_o | output | OP_W+3 | Exact sum of the eight operands |

## Verification
The bench builds the block with `OP_W = 8`, which gives an 11-bit result. At this width, random operands often carry into all three growth bits. Biased draws of all-ones and zero fields reach the largest total and the sparse single-slot patterns. The bench also tests each slot on its own, with particular attention to operands 6 and 7, which pass around the first compressor layer, and it tests the boundary of the prefix-adder carry.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;
  // number of operands the tree accepts
  localparam int NUM_OPS = 8;
  // growth bits needed to hold the total of NUM_OPS operands
  localparam int GROWTH  = $clog2(NUM_OPS);

  // vector count after one 3:2 layer: two per full group, leftovers pass
  function automatic int layer_out(input int in_cnt);
    return 2 * (in_cnt / 3) + (in_cnt % 3);
  endfunction
endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic ab_x;
  assign ab_x = a_i ^ b_i;
  assign s_o  = ab_x ^ c_i;
  assign co_o = (a_i & b_i) | (ab_x & c_i);
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 19
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  logic [W-1:0] co_raw;

  // independent full adders, no link between neighbouring positions
  for (genvar b = 0; b < W; b++) begin : g_bit
    csa_fa_cell u_fa (
      .a_i  (x_i[b]),
      .b_i  (y_i[b]),
      .c_i  (z_i[b]),
      .s_o  (sum_o[b]),
      .co_o (co_raw[b])
    );
  end

  // carry weight is one position higher; top bit is provably zero (width margin)
  assign cry_o = {co_raw[W-2:0], 1'b0};
endmodule

// File: rtl/csa_layer.sv
module csa_layer import csa_tree_pkg::*; #(
  parameter  int W       = 19,
  parameter  int IN_CNT  = 8,
  localparam int GROUPS  = IN_CNT / 3,
  localparam int LEFT    = IN_CNT % 3,
  localparam int OUT_CNT = layer_out(IN_CNT)
) (
  input  logic [IN_CNT-1:0][W-1:0]  vec_i,
  output logic [OUT_CNT-1:0][W-1:0] vec_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    csa_row #(.W(W)) u_row (
      .x_i   (vec_i[3*g]),
      .y_i   (vec_i[3*g+1]),
      .z_i   (vec_i[3*g+2]),
      .sum_o (vec_o[2*g]),
      .cry_o (vec_o[2*g+1])
    );
  end

  for (genvar r = 0; r < LEFT; r++) begin : g_pass
    assign vec_o[2*GROUPS+r] = vec_i[3*GROUPS+r];
  end
endmodule

// File: rtl/csa_prefix_cpa.sv
module csa_prefix_cpa #(
  parameter  int W    = 19,
  localparam int LVLS = $clog2(W)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [LVLS:0][W-1:0] gen_l;
  logic [LVLS:0][W-1:0] prp_l;
  logic [W-1:0]         cin_v;

  assign gen_l[0] = a_i & b_i;
  assign prp_l[0] = a_i ^ b_i;

  // parallel-prefix carry tree, span doubles each level
  for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_pos
      if (i >= (1 << lv)) begin : g_merge
        assign gen_l[lv+1][i] = gen_l[lv][i] |
                                (prp_l[lv][i] & gen_l[lv][i-(1<<lv)]);
        assign prp_l[lv+1][i] = prp_l[lv][i] & prp_l[lv][i-(1<<lv)];
      end else begin : g_keep
        assign gen_l[lv+1][i] = gen_l[lv][i];
        assign prp_l[lv+1][i] = prp_l[lv][i];
      end
    end
  end

  assign cin_v = {gen_l[LVLS][W-2:0], 1'b0};
  assign sum_o = prp_l[0] ^ cin_v;
endmodule

// File: rtl/csa_reduce8.sv
module csa_reduce8 import csa_tree_pkg::*; #(
  parameter  int OP_W  = 16,
  localparam int SUM_W = OP_W + GROWTH,
  localparam int N1    = layer_out(NUM_OPS),
  localparam int N2    = layer_out(N1),
  localparam int N3    = layer_out(N2),
  localparam int N4    = layer_out(N3)
) (
  input  logic [NUM_OPS*OP_W-1:0] opnd_i,
  output logic [SUM_W-1:0]        total_o
);
  logic [NUM_OPS-1:0][SUM_W-1:0] l0_vec;
  logic [N1-1:0][SUM_W-1:0]      l1_vec;
  logic [N2-1:0][SUM_W-1:0]      l2_vec;
  logic [N3-1:0][SUM_W-1:0]      l3_vec;
  logic [N4-1:0][SUM_W-1:0]      l4_vec;

  // zero-extend every operand to the full result width
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_ext
    assign l0_vec[k] = {{GROWTH{1'b0}}, opnd_i[k*OP_W +: OP_W]};
  end

  csa_layer #(.W(SUM_W), .IN_CNT(NUM_OPS)) u_lay1 (.vec_i(l0_vec), .vec_o(l1_vec));
  csa_layer #(.W(SUM_W), .IN_CNT(N1))      u_lay2 (.vec_i(l1_vec), .vec_o(l2_vec));
  csa_layer #(.W(SUM_W), .IN_CNT(N2))      u_lay3 (.vec_i(l2_vec), .vec_o(l3_vec));
  csa_layer #(.W(SUM_W), .IN_CNT(N3))      u_lay4 (.vec_i(l3_vec), .vec_o(l4_vec));

  csa_prefix_cpa #(.W(SUM_W)) u_cpa (
    .a_i   (l4_vec[0]),
    .b_i   (l4_vec[1]),
    .sum_o (total_o)
  );
endmodule

module csa_reduce8_chk import csa_tree_pkg::*; #(
  parameter  int OP_W  = 16,
  localparam int SUM_W = OP_W + GROWTH,
  localparam int ACC_W = SUM_W + GROWTH
) (
  input logic [NUM_OPS*OP_W-1:0]  opnd_i,
  input logic [SUM_W-1:0]         total_o,
  input logic [NUM_OPS*SUM_W-1:0] l1_f,
  input logic [NUM_OPS*SUM_W-1:0] l2_f,
  input logic [NUM_OPS*SUM_W-1:0] l3_f,
  input logic [NUM_OPS*SUM_W-1:0] l4_f
);
  function automatic logic [ACC_W-1:0] vsum(input logic [NUM_OPS*SUM_W-1:0] v);
    logic [ACC_W-1:0] acc = '0;
    for (int i = 0; i < NUM_OPS; i++) acc += ACC_W'(v[i*SUM_W +: SUM_W]);
    return acc;
  endfunction

  logic [ACC_W-1:0] op_tot, max_tot;

  always_comb begin
    op_tot = '0;
    for (int i = 0; i < NUM_OPS; i++) op_tot += ACC_W'(opnd_i[i*OP_W +: OP_W]);
    max_tot = ACC_W'(NUM_OPS) * ((ACC_W'(1) << OP_W) - ACC_W'(1));

    // R1
    sum_exact_chk: assert (ACC_W'(total_o) == op_tot)
      else $error("R1 total %0d expected %0d", total_o, op_tot);
    // R2
    no_overflow_chk: assert (ACC_W'(total_o) <= max_tot)
      else $error("R2 total %0d above %0d", total_o, max_tot);
    // R3
    layer1_keep_chk: assert (vsum(l1_f) == op_tot) else $error("R3 layer 1");
    // R3
    layer2_keep_chk: assert (vsum(l2_f) == op_tot) else $error("R3 layer 2");
    // R3
    layer3_keep_chk: assert (vsum(l3_f) == op_tot) else $error("R3 layer 3");
    // R3
    layer4_fit_chk: assert (vsum(l4_f) == op_tot && op_tot < (ACC_W'(1) << SUM_W))
      else $error("R3 layer 4");
    // R4
    carry_lsb_chk: assert (!l1_f[SUM_W] && !l1_f[3*SUM_W] && !l2_f[SUM_W] &&
                           !l2_f[3*SUM_W] && !l3_f[SUM_W] && !l4_f[SUM_W])
      else $error("R4 carry vector bit 0 set");
  end
endmodule

bind csa_reduce8 csa_reduce8_chk #(.OP_W(OP_W)) u_chk (
  .opnd_i  (opnd_i),
  .total_o (total_o),
  .l1_f    ({{(2*SUM_W){1'b0}}, l1_vec}),
  .l2_f    ({{(4*SUM_W){1'b0}}, l2_vec}),
  .l3_f    ({{(5*SUM_W){1'b0}}, l3_vec}),
  .l4_f    ({{(6*SUM_W){1'b0}}, l4_vec})
);

// File: tb/csa_reduce8_bench.sv
module csa_reduce8_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W  = 8;
  localparam int NOPS  = 8;
  localparam int SUM_W = OP_W + 3;

  logic clk = 1'b0;
  logic [NOPS*OP_W-1:0] opnd;
  logic [SUM_W-1:0]     total;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_reduce8 #(.OP_W(OP_W)) u_csa_reduce8 (.opnd_i(opnd), .total_o(total));

  function automatic logic [SUM_W-1:0] ref_sum(input logic [NOPS*OP_W-1:0] v);
    logic [SUM_W-1:0] acc = '0;
    for (int i = 0; i < NOPS; i++) acc += SUM_W'(v[i*OP_W +: OP_W]);
    return acc;
  endfunction

  task automatic apply(input logic [NOPS*OP_W-1:0] v);
    @(negedge clk);
    opnd = v;
    @(posedge clk);
    #1;
  endtask

  task automatic check_val(input string req, input logic [SUM_W-1:0] got,
                           input logic [SUM_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  initial begin
    logic [NOPS*OP_W-1:0] v;
    logic [SUM_W-1:0] low_ref;
    opnd = '0;
    void'($urandom(32'd1234));
    #1;
    // R6: zero input
    apply('0);
    check_val("R6 zero", total, '0);
    // R2: all ones
    apply('1);
    check_val("R2 all ones", total, SUM_W'(NOPS * ((1 << OP_W) - 1)));
    // R7: each slot alone
    for (int k = 0; k < NOPS; k++) begin
      v = '0;
      v[k*OP_W +: OP_W] = OP_W'(8'hA5 ^ k);
      apply(v);
      check_val($sformatf("R7 slot %0d", k), total, SUM_W'(OP_W'(8'hA5 ^ k)));
    end
    // R4: three ones need a carry moved up one place
    v = '0;
    for (int k = 0; k < 3; k++) v[k*OP_W] = 1'b1;
    apply(v);
    check_val("R4 three ones", total, SUM_W'(3));
    // R5: upper bits change, low 3 bits of total stay
    for (int t = 0; t < 20; t++) begin
      v = {$urandom, $urandom};
      apply(v);
      low_ref = total;
      for (int k = 0; k < NOPS; k++) v[k*OP_W+3 +: OP_W-3] = (OP_W-3)'($urandom);
      apply(v);
      check_val("R5 low bits", SUM_W'(total[2:0]), SUM_W'(low_ref[2:0]));
    end
    // R1 R3: biased random operands
    for (int t = 0; t < 400; t++) begin
      for (int k = 0; k < NOPS; k++) begin
        case ($urandom % 4)
          0: v[k*OP_W +: OP_W] = '1;
          1: v[k*OP_W +: OP_W] = '0;
          default: v[k*OP_W +: OP_W] = OP_W'($urandom);
        endcase
      end
      apply(v);
      check_val("R1 R3 random", total, ref_sum(v));
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule